// File: doc/BRIEF.md
# Bus Transfer Modifier Unit

This block sits on an internal transfer bus between a selected 16-bit source value and the register that receives it. On each transfer it can invert the source word. It then applies one of four modifications to the word: pass it unchanged, add one, rotate it left by one position through a link bit, or rotate it right by one position through the link bit. The modified word goes to the destination in the same cycle, together with a write enable.

Two flags are held in registers. The link bit takes part in both rotates. The byte-carry flag records the carry out of an add-one transfer. A display register watches the destination code. When the code matches a selector value supplied from outside, the display register takes a copy of the transferred word. Decoding of sources and destinations, and any memory, are left to neighbouring logic.

The operation field is four bits wide. Bit 1 requests inversion. Bits 3:2 pick the modification. Bit 0 is not used by this stage.

Top module: `bus_xfer_modifier`

## Requirements
- R1: A synchronous reset clears the link flag, the byte-carry flag and the display register to zero.
- R2: When op bit 1 is 1, the source word is inverted bit by bit before the modification is applied. With modification 00, the result is then the inverted source.
- R3: Modification code 00 in op bits 3:2 passes the (possibly inverted) word through unchanged and leaves both flags unchanged.
- R4: Modification code 01 gives the word plus one, wrapped to 16 bits. It sets the byte-carry flag when the addition carries out of bit 15 and clears it otherwise. The link flag is left unchanged.
- R5: Modification code 10 gives {word[14:0], link}. The link flag is loaded from word[15], and the byte-carry flag is left unchanged.
- R6: Modification code 11 gives {link, word[15:1]}. The link flag is loaded from word[0], and the byte-carry flag is left unchanged.
- R7: The write enable equals the strobe, and the result is valid combinationally in the strobe cycle. Both use the flag values held before the clock edge.
- R8: On a strobe cycle where the 6-bit destination code equals the 6-bit display selector, the display register loads the result at the clock edge. It holds its value otherwise.
- R9: In a cycle without a strobe, neither flag and not the display register changes.
- R10: Op bit 0 has no effect on the result or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_stb | input | 1 | A transfer occurs this cycle |
| src_word | input | 16 | Source value on the bus |
| op_field | input | 4 | Bit 1 inverts; bits 3:2 modification; bit 0 unused |
| dst_code | input | 6 | Destination code of this transfer |
| disp_sel | input | 6 | Destination code that the display register watches |
| xfer_res | output | 16 | Modified word to the destination |
| dst_we | output | 1 | Destination write enable |
| link_flag | output | 1 | Link flag |
| bcarry_flag | output | 1 | Byte-carry flag |
| disp_word | output | 16 | Display register |

## Verification
Two functions can act in the same cycle: a flag update from a rotate or an increment, and a display capture. This happens on any strobe whose destination code equals the selector. The bench sets the selector equal to the destination code of rotate and increment transfers, both in directed cases and in a long randomized run where the selector often matches. In each such cycle it checks that the display register holds the result computed from the link value before the edge, while the link flag has moved to its new value. Inversion combined with a rotate is exercised the same way, to confirm that the link is taken from the inverted word.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int OP_W     = 4;
    localparam int INV_BIT  = 1;
    localparam int FN_LSB   = 2;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_INC  = 2'b01,
        FN_ROL  = 2'b10,
        FN_ROR  = 2'b11
    } xfer_fn_e;
endpackage

// File: rtl/xfer_pre.sv
module xfer_pre #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic              inv_i,
    output logic [DATA_W-1:0] word_o
);
    // Per-bit conditional inversion, ahead of the modification stage (R2)
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_inv
        assign word_o[gi] = src_i[gi] ^ inv_i;
    end
endmodule

// File: rtl/xfer_func.sv
module xfer_func
    import xfer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  xfer_fn_e          fn_i,
    input  logic              link_i,
    output logic [DATA_W-1:0] res_o,
    output logic              link_upd_o,
    output logic              link_nx_o,
    output logic              carry_upd_o,
    output logic              carry_nx_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_w;
    assign sum_w = {1'b0, word_i} + {{DATA_W{1'b0}}, 1'b1};

    always_comb begin
        res_o       = word_i;
        link_upd_o  = 1'b0;
        link_nx_o   = link_i;
        carry_upd_o = 1'b0;
        carry_nx_o  = 1'b0;
        unique case (fn_i)
            FN_PASS: res_o = word_i;
            FN_INC: begin
                res_o       = sum_w[MSB:0];
                carry_upd_o = 1'b1;
                carry_nx_o  = sum_w[DATA_W];
            end
            FN_ROL: begin
                res_o      = {word_i[MSB-1:0], link_i};
                link_upd_o = 1'b1;
                link_nx_o  = word_i[MSB];
            end
            FN_ROR: begin
                res_o      = {link_i, word_i[MSB:1]};
                link_upd_o = 1'b1;
                link_nx_o  = word_i[0];
            end
            default: res_o = word_i;
        endcase
    end
endmodule

// File: rtl/xfer_state.sv
module xfer_state #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_i,
    input  logic              link_upd_i,
    input  logic              link_nx_i,
    input  logic              carry_upd_i,
    input  logic              carry_nx_i,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] cap_val_i,
    output logic              link_o,
    output logic              carry_o,
    output logic [DATA_W-1:0] disp_o
);
    typedef struct packed {
        logic              link;
        logic              carry;
        logic [DATA_W-1:0] disp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb_i) begin
            if (link_upd_i)  st_d.link  = link_nx_i;
            if (carry_upd_i) st_d.carry = carry_nx_i;
            if (cap_i)       st_d.disp  = cap_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign link_o  = st_q.link;
    assign carry_o = st_q.carry;
    assign disp_o  = st_q.disp;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!link_o && !carry_o && disp_o == '0)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> ($stable(link_o) && $stable(carry_o) && $stable(disp_o))); // R9
    AST_DISP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(stb_i && cap_i) |=> $stable(disp_o)); // R8
endmodule

// File: rtl/bus_xfer_modifier.sv
module bus_xfer_modifier
    import xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_stb,
    input  logic [DATA_W-1:0] src_word,
    input  logic [OP_W-1:0]   op_field,
    input  logic [SEL_W-1:0]  dst_code,
    input  logic [SEL_W-1:0]  disp_sel,
    output logic [DATA_W-1:0] xfer_res,
    output logic              dst_we,
    output logic              link_flag,
    output logic              bcarry_flag,
    output logic [DATA_W-1:0] disp_word
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] pre_w;
    logic              l_upd, l_nx, c_upd, c_nx;
    logic              sel_hit;
    xfer_fn_e          fn_w;
    logic              unused_opbit;

    assign fn_w         = xfer_fn_e'(op_field[FN_LSB +: 2]);
    assign unused_opbit = op_field[0];
    assign sel_hit      = (dst_code == disp_sel);
    assign dst_we       = xfer_stb;

    xfer_pre #(.DATA_W(DATA_W)) u_pre (
        .src_i  (src_word),
        .inv_i  (op_field[INV_BIT]),
        .word_o (pre_w)
    );

    xfer_func #(.DATA_W(DATA_W)) u_func (
        .word_i      (pre_w),
        .fn_i        (fn_w),
        .link_i      (link_flag),
        .res_o       (xfer_res),
        .link_upd_o  (l_upd),
        .link_nx_o   (l_nx),
        .carry_upd_o (c_upd),
        .carry_nx_o  (c_nx)
    );

    xfer_state #(.DATA_W(DATA_W)) u_state (
        .clk         (clk),
        .rst         (rst),
        .stb_i       (xfer_stb),
        .link_upd_i  (l_upd),
        .link_nx_i   (l_nx),
        .carry_upd_i (c_upd),
        .carry_nx_i  (c_nx),
        .cap_i       (sel_hit),
        .cap_val_i   (xfer_res),
        .link_o      (link_flag),
        .carry_o     (bcarry_flag),
        .disp_o      (disp_word)
    );

    AST_ROL_LINK: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && fn_w == FN_ROL) |=> link_flag == $past(pre_w[MSB])); // R5
    AST_ROR_LINK: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && fn_w == FN_ROR) |=> link_flag == $past(pre_w[0])); // R6
    AST_INC_CARRY: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && fn_w == FN_INC) |=> (bcarry_flag == $past(&pre_w) && $stable(link_flag))); // R4
    AST_PASS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && fn_w == FN_PASS) |=> ($stable(link_flag) && $stable(bcarry_flag))); // R3
    AST_DISP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (xfer_stb && dst_code == disp_sel) |=> disp_word == $past(xfer_res)); // R8
endmodule

// File: tb/bus_xfer_modifier_tb_top.sv
module bus_xfer_modifier_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        stb;
    logic [15:0] src;
    logic [3:0]  op;
    logic [5:0]  dst, sel;
    logic [15:0] res, disp;
    logic        we, link, bc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int r_link, r_bc, r_disp;

    always #4 clk = ~clk;

    bus_xfer_modifier dut_i (
        .clk(clk), .rst(rst), .xfer_stb(stb), .src_word(src), .op_field(op),
        .dst_code(dst), .disp_sel(sel), .xfer_res(res), .dst_we(we),
        .link_flag(link), .bcarry_flag(bc), .disp_word(disp)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural model of one transfer: returns result and next flags
    task automatic model(input int s, input int o, input int lk,
                         output int r, output int nl, output int nb, input int bc_in);
        int w, f;
        w  = ((o >> 1) & 1) ? (~s & 'hFFFF) : s;
        f  = (o >> 2) & 3;
        nl = lk;
        nb = bc_in;
        case (f)
            0: r = w;
            1: begin r = (w + 1) % 65536; nb = (w == 'hFFFF) ? 1 : 0; end
            2: begin r = ((w * 2) % 65536) + lk; nl = w / 32768; end
            default: begin r = (w / 2) + lk * 32768; nl = w % 2; end
        endcase
    endtask

    // one cycle: drive, check combinational outputs, clock, check state
    task automatic step(input string tag, input bit s_stb, input int s_src,
                        input int s_op, input int s_dst, input int s_sel);
        int er, nl, nb;
        stb = s_stb; src = s_src[15:0]; op = s_op[3:0];
        dst = s_dst[5:0]; sel = s_sel[5:0];
        #1;
        model(s_src & 'hFFFF, s_op & 'hF, r_link, er, nl, nb, r_bc);
        chk(tag, "dst_we", int'(we), int'(s_stb));
        if (s_stb) chk(tag, "result", int'(res), er);
        if (s_stb) begin
            r_link = nl; r_bc = nb;
            if ((s_dst & 63) == (s_sel & 63)) r_disp = er;
        end
        @(posedge clk); #1;
        chk(tag, "link", int'(link), r_link);
        chk(tag, "bcarry", int'(bc), r_bc);
        chk(tag, "display", int'(disp), r_disp);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; stb = 0; src = 16'hFFFF; op = 4'hF; dst = 0; sel = 0;
        // dirty the state first
        @(negedge clk); rst = 0;
        @(negedge clk); stb = 1; op = 4'b1000; src = 16'h8001; dst = 5; sel = 5;
        @(negedge clk); op = 4'b0100; src = 16'hFFFF;
        @(negedge clk); stb = 0; rst = 1;
        @(posedge clk); #1;
        r_link = 0; r_bc = 0; r_disp = 0;
        chk("R1", "link", int'(link), 0);
        chk("R1", "bcarry", int'(bc), 0);
        chk("R1", "display", int'(disp), 0);
        @(negedge clk); rst = 0;

        step("R3", 1, 'h1234, 4'b0000, 3, 3);          // pass, captured
        step("R2", 1, 'h1234, 4'b0010, 3, 3);          // invert
        step("R4", 1, 'hFFFF, 4'b0100, 1, 2);          // wrap, carry set
        step("R4", 1, 'h0010, 4'b0100, 1, 2);          // carry cleared
        step("R2", 1, 'h0000, 4'b0110, 9, 9);          // invert then inc: carry
        step("R5", 1, 'h8000, 4'b1000, 7, 7);          // rol, link<-1, captured same cycle
        step("R5", 1, 'h0001, 4'b1000, 7, 7);          // rol pulls link in
        step("R6", 1, 'h0001, 4'b1100, 8, 8);          // ror link<-1
        step("R6", 1, 'h0000, 4'b1100, 8, 2);          // ror pulls link into msb, no capture
        step("R2", 1, 'h7FFF, 4'b1010, 4, 4);          // invert then rol
        step("R10", 1, 'h5555, 4'b1001, 6, 6);         // bit 0 set, same as rol
        step("R10", 1, 'hFFFF, 4'b0101, 6, 6);         // bit 0 set, inc
        step("R9", 0, 'hFFFF, 4'b0100, 6, 6);          // no strobe: nothing moves
        step("R9", 0, 'h8000, 4'b1000, 6, 6);
        step("R8", 1, 'hABCD, 4'b0000, 10, 11);        // no match: hold display
        step("R7", 1, 'h0F0F, 4'b1110, 12, 12);

        for (int i = 0; i < 3000; i++) begin
            int ro, rs, rd, rl;
            ro = $urandom % 16;
            rs = $urandom % 65536;
            rd = $urandom % 64;
            rl = ($urandom % 2) ? rd : ($urandom % 64);
            case ((ro >> 2) & 3)
                0: step("R3", ($urandom % 4) != 0, rs, ro, rd, rl);
                1: step("R4", ($urandom % 4) != 0, (($urandom % 4) == 0) ? 'hFFFF : rs, ro, rd, rl);
                2: step("R5", ($urandom % 4) != 0, rs, ro, rd, rl);
                default: step("R6", ($urandom % 4) != 0, rs, ro, rd, rl);
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule